// File: doc/BRIEF.md
# Write-back set-associative data cache with range maintenance

This block is a write-back data cache with a configurable number of ways. It sits between a single CPU load/store port and a memory port that moves whole lines in bursts. A byte address is split into three fields: the line tag at the top, the set number in the middle and the byte position within the line at the bottom. Every way of the addressed set is compared in the same cycle. A load or store that hits completes in the cycle it is presented. A miss picks a victim way. If the victim holds modified data, that line is written back to memory first. The whole new line is then read into the victim way, and the request completes once it is in place.

Each stored tag also carries an address-space identifier. A hit needs both the tag and the identifier to agree. The same physical line may therefore be resident under several identifiers.

A maintenance port takes an inclusive byte-address range and one of three operations: write back dirty lines, drop lines, or both. Software uses it to keep DMA buffers coherent. The operation walks the range one line address at a time and matches stored tags under any identifier. While it runs, CPU requests wait.

Top module: `wb_assoc_cache`

## Requirements
- R1: Byte address bits [OFFB-1:BSELB] select the word within the line, bits [OFFB+IDXB-1:OFFB] give the set (index modulo SETS), and the bits above form the tag. With the defaults, line L word w is at byte address L*16 + w*4, in set L%16, with tag L/16.
- R2: A request to a resident line asserts cpu_ready in the same cycle as cpu_req, with no memory traffic. A load returns the stored word. A store replaces the word and marks the line dirty.
- R3: At most one way of a set matches a given tag and identifier.
- R4: A miss issues one read burst of WORDS beats at the line base address. Beat k fills word k. The request then completes with the fetched data.
- R5: A dirty victim is written back first, as WORDS write beats at its own line address. mem_req, mem_addr and mem_we stay stable through a burst until its last beat.
- R6: The victim is the lowest-numbered invalid way if one exists. Otherwise it is the way named by the set's round-robin pointer. Each fill sets that pointer to the filled way plus one, modulo WAYS.
- R7: A lookup whose tag matches but whose identifier differs is a miss. The refetched copy goes into another way, and the original copy still hits under its own identifier.
- R8: Operation code 01 (clean) writes back every dirty line whose line address lies in [mnt_lo, mnt_hi]. Those lines stay valid and become clean. Lines outside the range are not written.
- R9: Operation code 10 (invalidate) drops every line in the range without writing it back, so the next load refetches from memory. Lines outside the range keep hitting.
- R10: Operation code 11 writes back the dirty lines in the range and then drops them.
- R11: In an idle cycle, mnt_start wins over a simultaneous cpu_req. mnt_busy is high for the whole walk, cpu_ready stays low while it is high, and mnt_done pulses for exactly one cycle at the end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | CPU request, held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | Byte address |
| cpu_asid | input | ASIDW | Address-space identifier |
| cpu_wdata | input | DW | Store data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DW | Load data, valid with cpu_ready |
| mnt_start | input | 1 | Start a maintenance walk |
| mnt_op | input | 2 | Bit 0 = write back dirty lines, bit 1 = drop lines |
| mnt_lo | input | AW | First byte address of the range |
| mnt_hi | input | AW | Last byte address of the range (inclusive) |
| mnt_busy | output | 1 | Walk in progress |
| mnt_done | output | 1 | One-cycle pulse when the walk ends |
| mem_req | output | 1 | Burst request, held for the whole burst |
| mem_we | output | 1 | 1 = write burst, 0 = read burst |
| mem_addr | output | AW | Line base byte address |
| mem_wdata | output | DW | Write data for the current beat |
| mem_beat | input | 1 | A beat is transferred this cycle |
| mem_rdata | input | DW | Read data for the current beat |

## Verification
The two functions that can meet in one cycle are a CPU request and a maintenance start. Both arrive in the same idle cycle, and the request targets a dirty resident line inside the range of a write-back-and-drop walk. The bench checks four things. cpu_ready must stay low in that cycle even though the line would have hit. Two write-back bursts must land in memory with the values the CPU stored. The done pulse must come exactly once. The held request must then complete through a fresh read burst that returns the written-back data. Memory beats are throttled every third cycle, so the stability of the burst signals is also exercised.

// File: rtl/cache_pkg.sv
package cache_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WBACK,
      ST_FILL,
      ST_MSCAN,
      ST_MWB
   } cache_state_t;

   localparam logic [1:0] MOP_CLEAN = 2'b01;
   localparam logic [1:0] MOP_DROP  = 2'b10;

endpackage

// File: rtl/cache_prio_pick.sv
module cache_prio_pick #(
   parameter int N  = 4,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/cache_tag_cmp.sv
module cache_tag_cmp #(
   parameter int WAYS     = 4,
   parameter int TAGW     = 24,
   parameter int ASIDW    = 8,
   parameter bit USE_ASID = 1'b1
) (
   input  logic [WAYS-1:0]             way_vld,
   input  logic [WAYS-1:0][TAGW-1:0]   way_tag,
   input  logic [WAYS-1:0][ASIDW-1:0]  way_asid,
   input  logic [TAGW-1:0]             q_tag,
   input  logic [ASIDW-1:0]            q_asid,
   output logic [WAYS-1:0]             full_hit,
   output logic [WAYS-1:0]             tag_hit
);
   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign tag_hit[w] = way_vld[w] && (way_tag[w] == q_tag);
      if (USE_ASID) begin : g_asid
         assign full_hit[w] = tag_hit[w] && (way_asid[w] == q_asid);
      end else begin : g_noasid
         assign full_hit[w] = tag_hit[w];
      end
   end

   logic unused_asid;
   assign unused_asid = ^{way_asid, q_asid};
endmodule

// File: rtl/cache_victim_sel.sv
module cache_victim_sel #(
   parameter int WAYS = 4,
   parameter int WAYB = $clog2(WAYS)
) (
   input  logic [WAYS-1:0] way_vld,
   input  logic [WAYB-1:0] rr_ptr,
   output logic [WAYB-1:0] victim
);
   logic            free_found;
   logic [WAYB-1:0] free_way;

   cache_prio_pick #(.N(WAYS), .IW(WAYB)) u_free (
      .req   (~way_vld),
      .found (free_found),
      .idx   (free_way)
   );

   assign victim = free_found ? free_way : rr_ptr;
endmodule

// File: rtl/wb_assoc_cache.sv
module wb_assoc_cache
   import cache_pkg::*;
#(
   parameter int WAYS     = 4,
   parameter int SETS     = 16,
   parameter int WORDS    = 4,
   parameter int DW       = 32,
   parameter int AW       = 32,
   parameter int ASIDW    = 8,
   parameter bit USE_ASID = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_req,
   input  logic             cpu_we,
   input  logic [AW-1:0]    cpu_addr,
   input  logic [ASIDW-1:0] cpu_asid,
   input  logic [DW-1:0]    cpu_wdata,
   output logic             cpu_ready,
   output logic [DW-1:0]    cpu_rdata,
   input  logic             mnt_start,
   input  logic [1:0]       mnt_op,
   input  logic [AW-1:0]    mnt_lo,
   input  logic [AW-1:0]    mnt_hi,
   output logic             mnt_busy,
   output logic             mnt_done,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [DW-1:0]    mem_wdata,
   input  logic             mem_beat,
   input  logic [DW-1:0]    mem_rdata
);
   localparam int BSELB = $clog2(DW / 8);
   localparam int WSELB = $clog2(WORDS);
   localparam int OFFB  = WSELB + BSELB;
   localparam int IDXB  = $clog2(SETS);
   localparam int TAGW  = AW - OFFB - IDXB;
   localparam int LINEW = AW - OFFB;
   localparam int WAYB  = $clog2(WAYS);

   // elaboration-time parameter checks
   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
      $error("WORDS must be a power of two of at least 2");
   end
   if (DW < 8 || (DW & (DW - 1)) != 0) begin : g_bad_dw
      $error("DW must be a power-of-two number of bits, at least 8");
   end
   if (TAGW < 1) begin : g_bad_aw
      $error("AW too small for the chosen geometry");
   end

   // storage
   logic [WAYS-1:0][TAGW-1:0]  tag_q  [SETS];
   logic [WAYS-1:0][ASIDW-1:0] asid_q [SETS];
   logic [WAYS-1:0]            vld_q  [SETS];
   logic [WAYS-1:0]            dty_q  [SETS];
   logic [WAYB-1:0]            rr_q   [SETS];
   logic [DW-1:0]              dat_q  [SETS][WAYS][WORDS];

   // control state
   cache_state_t     st_q;
   logic [WSELB-1:0] beat_q;
   logic [WAYB-1:0]  vic_q;
   logic [LINEW-1:0] m_line_q, m_end_q;
   logic [1:0]       m_op_q;
   logic             done_q;

   // CPU address fields (R1)
   logic [WSELB-1:0] c_word;
   logic [IDXB-1:0]  c_set;
   logic [TAGW-1:0]  c_tag;
   assign c_word = cpu_addr[OFFB-1:BSELB];
   assign c_set  = cpu_addr[OFFB+IDXB-1:OFFB];
   assign c_tag  = cpu_addr[AW-1:OFFB+IDXB];

   // maintenance walk fields
   logic [IDXB-1:0] m_set;
   logic [TAGW-1:0] m_tag;
   assign m_set = m_line_q[IDXB-1:0];
   assign m_tag = m_line_q[LINEW-1:IDXB];

   logic in_mnt;
   assign in_mnt = (st_q == ST_MSCAN) || (st_q == ST_MWB);

   logic [IDXB-1:0] lk_set;
   logic [TAGW-1:0] lk_tag;
   assign lk_set = in_mnt ? m_set : c_set;
   assign lk_tag = in_mnt ? m_tag : c_tag;

   logic [WAYS-1:0] hit_vec, tag_vec;
   cache_tag_cmp #(
      .WAYS(WAYS), .TAGW(TAGW), .ASIDW(ASIDW), .USE_ASID(USE_ASID)
   ) u_cmp (
      .way_vld  (vld_q[lk_set]),
      .way_tag  (tag_q[lk_set]),
      .way_asid (asid_q[lk_set]),
      .q_tag    (lk_tag),
      .q_asid   (cpu_asid),
      .full_hit (hit_vec),
      .tag_hit  (tag_vec)
   );

   logic            hit_any;
   logic [WAYB-1:0] hit_way;
   cache_prio_pick #(.N(WAYS), .IW(WAYB)) u_hit_enc (
      .req   (hit_vec),
      .found (hit_any),
      .idx   (hit_way)
   );

   logic [WAYB-1:0] victim;
   cache_victim_sel #(.WAYS(WAYS), .WAYB(WAYB)) u_vic (
      .way_vld (vld_q[c_set]),
      .rr_ptr  (rr_q[c_set]),
      .victim  (victim)
   );

   // maintenance candidates: matching line needing work under the current op
   logic [WAYS-1:0] cand_vec;
   for (genvar w = 0; w < WAYS; w++) begin : g_cand
      assign cand_vec[w] = tag_vec[w] &&
                           ((m_op_q[0] && dty_q[m_set][w]) || m_op_q[1]);
   end

   logic            cand_any;
   logic [WAYB-1:0] cand_way;
   cache_prio_pick #(.N(WAYS), .IW(WAYB)) u_cand_enc (
      .req   (cand_vec),
      .found (cand_any),
      .idx   (cand_way)
   );

   logic last_beat;
   assign last_beat = mem_beat && (beat_q == WSELB'(WORDS - 1));

   // CPU side outputs (R2, R11)
   assign cpu_ready = (st_q == ST_IDLE) && cpu_req && !mnt_start && hit_any;
   assign cpu_rdata = dat_q[c_set][hit_way][c_word];

   assign mnt_busy = in_mnt;
   assign mnt_done = done_q;

   // memory side outputs (R4, R5, R8)
   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      unique case (st_q)
         ST_WBACK: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = {tag_q[c_set][vic_q], c_set, {OFFB{1'b0}}};
            mem_wdata = dat_q[c_set][vic_q][beat_q];
         end
         ST_FILL: begin
            mem_req  = 1'b1;
            mem_addr = {c_tag, c_set, {OFFB{1'b0}}};
         end
         ST_MWB: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = {m_line_q, {OFFB{1'b0}}};
            mem_wdata = dat_q[m_set][vic_q][beat_q];
         end
         default: ;
      endcase
   end

   // control and line status
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         beat_q   <= '0;
         vic_q    <= '0;
         m_line_q <= '0;
         m_end_q  <= '0;
         m_op_q   <= '0;
         done_q   <= 1'b0;
         for (int s = 0; s < SETS; s++) begin
            vld_q[s] <= '0;
            dty_q[s] <= '0;
            rr_q[s]  <= '0;
         end
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               beat_q <= '0;
               if (mnt_start) begin
                  m_line_q <= mnt_lo[AW-1:OFFB];
                  m_end_q  <= mnt_hi[AW-1:OFFB];
                  m_op_q   <= mnt_op;
                  st_q     <= ST_MSCAN;
               end else if (cpu_req) begin
                  if (hit_any) begin
                     if (cpu_we) dty_q[c_set][hit_way] <= 1'b1;
                  end else begin
                     vic_q <= victim;
                     st_q  <= (vld_q[c_set][victim] && dty_q[c_set][victim])
                              ? ST_WBACK : ST_FILL;
                  end
               end
            end
            ST_WBACK: begin
               if (mem_beat) beat_q <= beat_q + 1'b1;
               if (last_beat) begin
                  dty_q[c_set][vic_q] <= 1'b0;
                  vld_q[c_set][vic_q] <= 1'b0;
                  st_q                <= ST_FILL;
               end
            end
            ST_FILL: begin
               if (mem_beat) beat_q <= beat_q + 1'b1;
               if (last_beat) begin
                  vld_q[c_set][vic_q] <= 1'b1;
                  dty_q[c_set][vic_q] <= 1'b0;
                  rr_q[c_set]         <= vic_q + 1'b1;
                  st_q                <= ST_IDLE;
               end
            end
            ST_MSCAN: begin
               beat_q <= '0;
               if (cand_any) begin
                  if (m_op_q[0] && dty_q[m_set][cand_way]) begin
                     vic_q <= cand_way;
                     st_q  <= ST_MWB;
                  end else begin
                     vld_q[m_set][cand_way] <= 1'b0;
                     dty_q[m_set][cand_way] <= 1'b0;
                  end
               end else if (m_line_q >= m_end_q) begin
                  done_q <= 1'b1;
                  st_q   <= ST_IDLE;
               end else begin
                  m_line_q <= m_line_q + 1'b1;
               end
            end
            ST_MWB: begin
               if (mem_beat) beat_q <= beat_q + 1'b1;
               if (last_beat) begin
                  dty_q[m_set][vic_q] <= 1'b0;
                  if (m_op_q[1]) vld_q[m_set][vic_q] <= 1'b0;
                  st_q <= ST_MSCAN;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // tag, identifier and data arrays (no reset)
   always_ff @(posedge clk) begin
      if (cpu_ready && cpu_we)
         dat_q[c_set][hit_way][c_word] <= cpu_wdata;
      if (st_q == ST_FILL && mem_beat)
         dat_q[c_set][vic_q][beat_q] <= mem_rdata;
      if (st_q == ST_FILL && last_beat) begin
         tag_q[c_set][vic_q]  <= c_tag;
         asid_q[c_set][vic_q] <= cpu_asid;
      end
   end

   logic unused_bits;
   assign unused_bits = ^{cpu_addr[BSELB-1:0], mnt_lo[OFFB-1:0], mnt_hi[OFFB-1:0]};

   // assertions
   a_r3_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   a_r11_cpu_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      mnt_busy |-> !cpu_ready);

   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      mnt_done |=> !mnt_done);

   a_r5_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_beat) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   a_r2_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> !mem_req);
endmodule

// File: tb/sim_wb_assoc_cache.sv
module sim_wb_assoc_cache;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [31:0] cpu_addr = '0;
   logic [7:0]  cpu_asid = '0;
   logic [31:0] cpu_wdata = '0;
   logic        cpu_ready;
   logic [31:0] cpu_rdata;
   logic        mnt_start = 1'b0;
   logic [1:0]  mnt_op = '0;
   logic [31:0] mnt_lo = '0, mnt_hi = '0;
   logic        mnt_busy, mnt_done;
   logic        mem_req, mem_we, mem_beat = 1'b0;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;

   always #5 clk = ~clk;

   wb_assoc_cache u0 (
      .clk, .rst_n, .cpu_req, .cpu_we, .cpu_addr, .cpu_asid, .cpu_wdata,
      .cpu_ready, .cpu_rdata, .mnt_start, .mnt_op, .mnt_lo, .mnt_hi,
      .mnt_busy, .mnt_done, .mem_req, .mem_we, .mem_addr, .mem_wdata,
      .mem_beat, .mem_rdata
   );

   // memory model, shadow of CPU-visible contents
   logic [31:0] mem [1024];
   logic [31:0] sh  [1024];
   int bcnt = 0, rd_b = 0, wr_b = 0, gap = 0, done_cnt = 0;
   logic [31:0] last_wa = '0;
   int total = 0, bad = 0;

   assign mem_rdata = mem[((mem_addr >> 2) + bcnt) & 1023];

   always @(negedge clk) begin
      gap++;
      mem_beat = mem_req && (gap % 3 != 0);
      if (mnt_done) done_cnt++;
   end

   always @(posedge clk) begin
      if (mem_req && mem_beat) begin
         if (mem_we) mem[((mem_addr >> 2) + bcnt) & 1023] <= mem_wdata;
         if (bcnt == 3) begin
            bcnt <= 0;
            if (mem_we) begin
               wr_b <= wr_b + 1;
               last_wa <= mem_addr;
            end else rd_b <= rd_b + 1;
         end else bcnt <= bcnt + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ad(input int line, input int word);
      return 32'(line * 16 + word * 4);
   endfunction

   task automatic cpu_op(input bit we, input int line, input int word, input int asid,
                         input logic [31:0] wd, output logic [31:0] rd, output int waitc);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = ad(line, word);
      cpu_asid = 8'(asid); cpu_wdata = wd;
      waitc = 0;
      #1;
      while (!cpu_ready && waitc < 3000) begin
         @(negedge clk); #1; waitc++;
      end
      rd = cpu_rdata;
      @(posedge clk); #1;
      cpu_req = 1'b0; cpu_we = 1'b0;
      if (we) sh[line * 4 + word] = wd;
   endtask

   task automatic mnt_run(input logic [1:0] op, input int lo_line, input int hi_line);
      int n;
      @(negedge clk);
      mnt_start = 1'b1; mnt_op = op;
      mnt_lo = ad(lo_line, 0); mnt_hi = ad(hi_line, 3);
      @(posedge clk); #1;
      mnt_start = 1'b0;
      n = 0;
      while (mnt_busy && n < 3000) begin @(negedge clk); n++; end
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      int wc, rb0, wb0, dc0;
      for (int i = 0; i < 1024; i++) begin
         mem[i] = 32'hA000_0000 + 32'(i * 7);
         sh[i]  = mem[i];
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk(!cpu_ready && !mnt_busy && !mnt_done, "R11 reset idle", cpu_ready, 0);
      chk(!mem_req, "R4 reset no burst", mem_req, 0);

      // R1/R4: sweep every set and word; first touch misses
      for (int l = 0; l < 16; l++) begin
         for (int w = 0; w < 4; w++) begin
            cpu_op(0, l, w, 0, 0, rd, wc);
            chk(rd == sh[l * 4 + w], "R1 R4 load value", rd, sh[l * 4 + w]);
            if (w == 0) chk(wc > 0, "R4 first touch misses", wc, 1);
            else chk(wc == 0, "R2 later words hit", wc, 0);
         end
      end
      chk(rd_b == 16 && wr_b == 0, "R4 one burst per line", rd_b, 16);

      // R2: stores hit and mark dirty, no memory traffic
      rb0 = rd_b;
      for (int l = 0; l < 16; l++) begin
         cpu_op(1, l, l % 4, 0, 32'h5000_0000 + 32'(l), rd, wc);
         chk(wc == 0, "R2 store hit same cycle", wc, 0);
      end
      for (int l = 0; l < 16; l++) begin
         cpu_op(0, l, l % 4, 0, 0, rd, wc);
         chk(rd == sh[l * 4 + l % 4], "R2 store readback", rd, sh[l * 4 + l % 4]);
      end
      chk(rd_b == rb0 && wr_b == 0, "R2 no memory traffic", rd_b, rb0);

      // R5/R6: fill set 0 and evict
      rb0 = rd_b; wb0 = wr_b;
      cpu_op(0, 16, 0, 0, 0, rd, wc);
      cpu_op(0, 32, 0, 0, 0, rd, wc);
      cpu_op(0, 48, 0, 0, 0, rd, wc);
      chk(rd_b == rb0 + 3 && wr_b == wb0, "R6 invalid ways first", wr_b, wb0);
      cpu_op(0, 64, 1, 0, 0, rd, wc);
      chk(rd == sh[64 * 4 + 1], "R4 refill value", rd, sh[64 * 4 + 1]);
      chk(wr_b == wb0 + 1 && last_wa == 0, "R6 R5 round-robin evicts dirty way 0", last_wa, 0);
      chk(mem[0] == sh[0] && mem[3] == sh[3], "R5 written-back data", mem[0], sh[0]);
      cpu_op(0, 80, 0, 0, 0, rd, wc);
      chk(wr_b == wb0 + 1, "R6 next victim way 1 is clean", wr_b, wb0 + 1);
      cpu_op(0, 0, 0, 0, 0, rd, wc);
      chk(wc > 0 && rd == sh[0], "R5 evicted line refetched", rd, sh[0]);

      // R7: identifier mismatch misses
      rb0 = rd_b;
      cpu_op(0, 1, 0, 5, 0, rd, wc);
      chk(wc > 0 && rd_b == rb0 + 1, "R7 other identifier misses", rd_b, rb0 + 1);
      cpu_op(0, 1, 1, 0, 0, rd, wc);
      chk(wc == 0 && rd == sh[5], "R7 original copy still hits", rd, sh[5]);

      // R8: clean lines 1..3
      wb0 = wr_b;
      mnt_run(2'b01, 1, 3);
      chk(wr_b == wb0 + 3, "R8 dirty lines in range written", wr_b, wb0 + 3);
      chk(mem[1 * 4 + 1] == sh[1 * 4 + 1] && mem[3 * 4 + 3] == sh[3 * 4 + 3],
          "R8 memory holds stored data", mem[3 * 4 + 3], sh[3 * 4 + 3]);
      chk(mem[4 * 4] != sh[4 * 4], "R8 line outside range untouched", mem[16], 32'hA000_0000 + 112);
      rb0 = rd_b;
      cpu_op(0, 2, 2, 0, 0, rd, wc);
      chk(wc == 0 && rd_b == rb0, "R8 cleaned line stays valid", wc, 0);
      wb0 = wr_b;
      mnt_run(2'b01, 1, 3);
      chk(wr_b == wb0, "R8 cleaned lines not dirty", wr_b, wb0);

      // R9: invalidate after inbound DMA
      for (int i = 20; i < 28; i++) begin
         mem[i] = 32'hD0A0_0000 + 32'(i);
         sh[i]  = mem[i];
      end
      wb0 = wr_b;
      mnt_run(2'b10, 5, 6);
      chk(wr_b == wb0, "R9 no write-back on drop", wr_b, wb0);
      cpu_op(0, 5, 1, 0, 0, rd, wc);
      chk(wc > 0 && rd == sh[21], "R9 refetch sees new data", rd, sh[21]);
      cpu_op(0, 6, 2, 0, 0, rd, wc);
      chk(wc > 0 && rd == sh[26], "R9 second line dropped", rd, sh[26]);
      cpu_op(0, 7, 3, 0, 0, rd, wc);
      chk(wc == 0 && rd == sh[31], "R9 outside range still hits", rd, sh[31]);

      // R10/R11: maintenance and CPU request in the same cycle
      rb0 = rd_b; wb0 = wr_b; dc0 = done_cnt;
      @(negedge clk);
      mnt_start = 1'b1; mnt_op = 2'b11; mnt_lo = ad(8, 0); mnt_hi = ad(9, 3);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = ad(8, 0); cpu_asid = 8'd0;
      #1;
      chk(!cpu_ready, "R11 maintenance wins", cpu_ready, 0);
      @(posedge clk); #1;
      mnt_start = 1'b0;
      wc = 0;
      while (!cpu_ready && wc < 3000) begin
         @(negedge clk); #1; wc++;
         if (mnt_busy && cpu_ready) chk(0, "R11 stall while busy", cpu_ready, 0);
      end
      rd = cpu_rdata;
      @(posedge clk); #1;
      cpu_req = 1'b0;
      chk(rd == sh[32], "R10 load after write-back and drop", rd, sh[32]);
      chk(wr_b == wb0 + 2, "R10 two dirty lines written", wr_b, wb0 + 2);
      chk(rd_b == rb0 + 1, "R10 dropped line refetched", rd_b, rb0 + 1);
      chk(mem[9 * 4 + 1] == sh[9 * 4 + 1], "R10 memory updated", mem[37], sh[37]);
      chk(done_cnt == dc0 + 1, "R11 single done pulse", done_cnt, dc0 + 1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule